// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Controller

This block resolves read-after-write dependences in a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it compares the two source register numbers of the instruction entering the ALU with the destination numbers of the two older instructions still in flight. It then emits one 2-bit select code per ALU operand. The code steers the operand multiplexer to the memory-stage result, to the writeback-stage result, or to the value read from the register file.

A producer that has reached writeback is covered by the register file contained in the block. The file passes a same-cycle write straight through to any read port that names the same register.

Some dependences cannot be covered by forwarding. The case is a load in execute whose destination is a source of the instruction in decode. For this case the block holds the program counter and the fetch/decode register for one cycle and zeroes the control word that enters the decode/execute register, which inserts one bubble. Instruction decoding, the ALU and the memories are outside the block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `fwd_a` is 2'b10 whenever `mem_wr_en` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs`.
- R2: `fwd_b` is 2'b10 whenever `mem_wr_en` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rt`.
- R3: If R1 (or R2) does not apply to an operand, its select code is 2'b01 when `wb_wr_en` is 1, `wb_rd` is nonzero and `wb_rd` equals that operand's source number.
- R4: When both older stages match one source, the memory-stage code 2'b10 wins. When neither stage matches, the code is 2'b00. The code 2'b11 never appears.
- R5: A destination of register 0 never produces a forwarding code at either stage.
- R6: The stall condition is: `ex_mem_read` is 1, `ex_rd` is nonzero, and `ex_rd` equals `id_rs` or `id_rt`. While the condition holds, `bubble` is 1, `pc_we` is 0, `ifid_we` is 0 and `id_ctrl_out` is all zeros. Otherwise `bubble` is 0, `pc_we` and `ifid_we` are 1, and `id_ctrl_out` equals `id_ctrl_in`.
- R7: In a pipeline driven by this block, a load followed at once by a consumer of its result costs exactly one bubble. Back-to-back ALU dependences cost none, and a load whose consumer is two instructions later also costs none.
- R8: On a rising clock edge with `wb_wr_en` 1 and `wb_rd` nonzero, `wb_data` is stored, and later reads of that register return it.
- R9: A read port addressing the register being written in the same cycle (nonzero) returns `wb_data` directly.
- R10: Register 0 reads as zero at all times. Writes to register 0 are discarded and never bypassed.
- R11: Synchronous reset clears every register of the file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | ADDR_W | First source register of the instruction in decode |
| id_rt | input | ADDR_W | Second source register of the instruction in decode |
| id_ctrl_in | input | CTRL_W | Control word produced by the decoder |
| ex_rs | input | ADDR_W | First source register held in the decode/execute register |
| ex_rt | input | ADDR_W | Second source register held in the decode/execute register |
| ex_rd | input | ADDR_W | Destination held in the decode/execute register |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| mem_wr_en | input | 1 | Execute/memory instruction writes a register |
| mem_rd | input | ADDR_W | Execute/memory destination register |
| wb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| wb_rd | input | ADDR_W | Memory/writeback destination register |
| wb_data | input | DATA_W | Result being written back |
| fwd_a | output | 2 | Operand A select: 00 file, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | A bubble is being inserted this cycle |
| id_ctrl_out | output | CTRL_W | Control word to the decode/execute register |
| rd_data_a | output | DATA_W | Register file read data for `id_rs` |
| rd_data_b | output | DATA_W | Register file read data for `id_rt` |

## Verification
The hardest case to bring about is the release of the stall. The stall ends only because the bubble itself reaches execute and clears the load flag, so the timing depends on a pipeline that the block does not contain. The bench therefore builds a small behavioural pipeline around the block. It advances the model using the block's own `pc_we`, `ifid_we` and `bubble`, runs short programs through it, and counts the bubbles.

Same-cycle bypass is a second awkward case, because it needs a writeback and a decode read of the same register in one cycle. Directed cycles set this up explicitly and also try the same thing on register 0.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;

    // Operand source selection for the ALU input multiplexers
    typedef enum logic [1:0] {
        FWD_NONE     = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_e;

    // Number of ALU operands that need a select code
    localparam int OPERANDS = 2;

    // The newer producer is preferred over the older one
    function automatic fwd_sel_e pick_source(input logic near_hit, input logic far_hit);
        if (near_hit) begin
            return FWD_FROM_MEM;
        end
        if (far_hit) begin
            return FWD_FROM_WB;
        end
        return FWD_NONE;
    endfunction

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import pipe_hz_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_rd,
    input  logic              wb_wr_en,
    input  logic [ADDR_W-1:0] wb_rd,
    output fwd_sel_e          sel
);

    logic near_hit;
    logic far_hit;

    // Register 0 is hard-wired, so it never counts as a producer
    assign near_hit = mem_wr_en && (mem_rd != '0) && (mem_rd == src);
    assign far_hit  = wb_wr_en  && (wb_rd  != '0) && (wb_rd  == src);

    assign sel = pick_source(near_hit, far_hit);

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int ADDR_W = 5
) (
    input  logic              ex_mem_read,
    input  logic [ADDR_W-1:0] ex_rd,
    input  logic [ADDR_W-1:0] id_rs,
    input  logic [ADDR_W-1:0] id_rt,
    output logic              stall
);

    logic dst_live;
    logic src_hit;

    assign dst_live = ex_mem_read && (ex_rd != '0);
    assign src_hit  = (ex_rd == id_rs) || (ex_rd == id_rt);
    assign stall    = dst_live && src_hit;

endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PORTS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr [PORTS],
    output logic [DATA_W-1:0] rd_data [PORTS]
);

    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [NREG];
    logic              wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_live) begin
            cells[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_read
        always_comb begin
            if (rd_addr[p] == '0) begin
                rd_data[p] = '0;
            end else if (wr_live && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = cells[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import pipe_hz_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] id_rs,
    input  logic [ADDR_W-1:0] id_rt,
    input  logic [CTRL_W-1:0] id_ctrl_in,
    input  logic [ADDR_W-1:0] ex_rs,
    input  logic [ADDR_W-1:0] ex_rt,
    input  logic [ADDR_W-1:0] ex_rd,
    input  logic              ex_mem_read,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_rd,
    input  logic              wb_wr_en,
    input  logic [ADDR_W-1:0] wb_rd,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble,
    output logic [CTRL_W-1:0] id_ctrl_out,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [ADDR_W-1:0] ex_src  [OPERANDS];
    logic [ADDR_W-1:0] id_src  [OPERANDS];
    logic [DATA_W-1:0] id_data [OPERANDS];
    fwd_sel_e          op_sel  [OPERANDS];
    logic              stall;

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;
    assign id_src[0] = id_rs;
    assign id_src[1] = id_rt;

    // One forwarding selector per ALU operand
    for (genvar k = 0; k < OPERANDS; k++) begin : g_operand
        hz_fwd_pick #(
            .ADDR_W (ADDR_W)
        ) i_pick (
            .src       (ex_src[k]),
            .mem_wr_en (mem_wr_en),
            .mem_rd    (mem_rd),
            .wb_wr_en  (wb_wr_en),
            .wb_rd     (wb_rd),
            .sel       (op_sel[k])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hz_load_use #(
        .ADDR_W (ADDR_W)
    ) i_load_use (
        .ex_mem_read (ex_mem_read),
        .ex_rd       (ex_rd),
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .stall       (stall)
    );

    // Freeze the front end and turn the decode slot into a no-op
    assign bubble      = stall;
    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign id_ctrl_out = stall ? '0 : id_ctrl_in;

    hz_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORTS  (OPERANDS)
    ) i_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_wr_en),
        .wr_addr (wb_rd),
        .wr_data (wb_data),
        .rd_addr (id_src),
        .rd_data (id_data)
    );

    assign rd_data_a = id_data[0];
    assign rd_data_b = id_data[1];

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] id_rs,
    input logic [ADDR_W-1:0] ex_rs,
    input logic [ADDR_W-1:0] ex_rt,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_rd,
    input logic              wb_wr_en,
    input logic [ADDR_W-1:0] wb_rd,
    input logic [DATA_W-1:0] wb_data,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              bubble,
    input logic [CTRL_W-1:0] id_ctrl_out,
    input logic [DATA_W-1:0] rd_data_a
);

    AST_FWD_A_NEAR: assert property (@(posedge clk) disable iff (rst)
        (fwd_a == 2'b10) |-> (mem_wr_en && mem_rd != '0 && mem_rd == ex_rs)); // R1

    AST_FWD_B_NEAR: assert property (@(posedge clk) disable iff (rst)
        (fwd_b == 2'b10) |-> (mem_wr_en && mem_rd != '0 && mem_rd == ex_rt)); // R2

    AST_FWD_A_FAR: assert property (@(posedge clk) disable iff (rst)
        (fwd_a == 2'b01) |-> (wb_wr_en && wb_rd != '0 && wb_rd == ex_rs
                              && !(mem_wr_en && mem_rd != '0 && mem_rd == ex_rs))); // R3

    AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R4

    AST_NEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_rd != '0 && mem_rd == ex_rt && wb_wr_en && wb_rd == ex_rt)
        |-> (fwd_b == 2'b10)); // R4

    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        (ex_rs == '0) |-> (fwd_a == 2'b00)); // R5

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (!pc_we && !ifid_we && id_ctrl_out == '0)); // R6

    AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wb_wr_en && wb_rd != '0 && wb_rd == id_rs)
        ##1 (id_rs == $past(id_rs) && !(wb_wr_en && wb_rd == id_rs))
        |-> (rd_data_a == $past(wb_data))); // R8

    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (wb_wr_en && wb_rd != '0 && wb_rd == id_rs) |-> (rd_data_a == wb_data)); // R9

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
        (id_rs == '0) |-> (rd_data_a == '0)); // R10

endmodule

bind pipe_hazard_ctrl hz_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) i_hz_checker (
    .clk         (clk),
    .rst         (rst),
    .id_rs       (id_rs),
    .ex_rs       (ex_rs),
    .ex_rt       (ex_rt),
    .mem_wr_en   (mem_wr_en),
    .mem_rd      (mem_rd),
    .wb_wr_en    (wb_wr_en),
    .wb_rd       (wb_rd),
    .wb_data     (wb_data),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .bubble      (bubble),
    .id_ctrl_out (id_ctrl_out),
    .rd_data_a   (rd_data_a)
);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 32;
    localparam int CTRL_W     = 8;
    localparam int NVEC       = 11;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic [CTRL_W-1:0] id_ctrl_in, id_ctrl_out;
    logic              ex_mem_read, mem_wr_en, wb_wr_en;
    logic [DATA_W-1:0] wb_data, rd_data_a, rd_data_b;
    logic [1:0]        fwd_a, fwd_b;
    logic              pc_we, ifid_we, bubble;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) i_pipe_hazard_ctrl (
        .clk (clk), .rst (rst),
        .id_rs (id_rs), .id_rt (id_rt), .id_ctrl_in (id_ctrl_in),
        .ex_rs (ex_rs), .ex_rt (ex_rt), .ex_rd (ex_rd), .ex_mem_read (ex_mem_read),
        .mem_wr_en (mem_wr_en), .mem_rd (mem_rd),
        .wb_wr_en (wb_wr_en), .wb_rd (wb_rd), .wb_data (wb_data),
        .fwd_a (fwd_a), .fwd_b (fwd_b), .pc_we (pc_we), .ifid_we (ifid_we),
        .bubble (bubble), .id_ctrl_out (id_ctrl_out),
        .rd_data_a (rd_data_a), .rd_data_b (rd_data_b)
    );

    // {ex_rs, ex_rt, mem_wr_en, mem_rd, wb_wr_en, wb_rd, exp_fwd_a, exp_fwd_b}
    localparam logic [25:0] VECS [NVEC] = '{
        {5'd1,  5'd2,  1'b1, 5'd1,  1'b0, 5'd0,  2'b10, 2'b00},  // R1
        {5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10},  // R2
        {5'd5,  5'd6,  1'b0, 5'd0,  1'b1, 5'd5,  2'b01, 2'b00},  // R3
        {5'd7,  5'd8,  1'b0, 5'd0,  1'b1, 5'd8,  2'b00, 2'b01},  // R3
        {5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  2'b10, 2'b10},  // R4 priority
        {5'd10, 5'd11, 1'b1, 5'd11, 1'b1, 5'd10, 2'b01, 2'b10},  // R3 R4 mixed
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},  // R5
        {5'd12, 5'd13, 1'b0, 5'd12, 1'b0, 5'd13, 2'b00, 2'b00},  // R4 writes off
        {5'd14, 5'd14, 1'b1, 5'd15, 1'b1, 5'd16, 2'b00, 2'b00},  // R4 no match
        {5'd17, 5'd18, 1'b1, 5'd17, 1'b1, 5'd18, 2'b10, 2'b01},  // R1 R3
        {5'd0,  5'd3,  1'b1, 5'd0,  1'b1, 5'd3,  2'b00, 2'b01}   // R5 R3
    };

    // Program memory for the pipeline model: {load, writes, rd, rs, rt}
    logic [16:0] prog_mem [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        id_rs = '0; id_rt = '0; id_ctrl_in = 8'h5A;
        ex_rs = '0; ex_rt = '0; ex_rd = '0; ex_mem_read = 1'b0;
        mem_wr_en = 1'b0; mem_rd = '0;
        wb_wr_en = 1'b0; wb_rd = '0; wb_data = '0;
    endtask

    task automatic run_pipe(input int n_instr, input int exp_bub, input string tag);
        logic [16:0] ifid, idex, exmem, memwb;
        int pc;
        int bub;
        ifid = '0; idex = '0; exmem = '0; memwb = '0; pc = 0; bub = 0;
        for (int c = 0; c < n_instr + 6; c++) begin
            @(negedge clk);
            id_rs = ifid[9:5];  id_rt = ifid[4:0]; id_ctrl_in = 8'h01;
            ex_rs = idex[9:5];  ex_rt = idex[4:0]; ex_rd = idex[14:10];
            ex_mem_read = idex[16];
            mem_wr_en = exmem[15]; mem_rd = exmem[14:10];
            wb_wr_en = memwb[15];  wb_rd = memwb[14:10]; wb_data = 32'(c);
            #1;
            if (bubble) bub++;
            memwb = exmem;
            exmem = idex;
            idex  = bubble ? 17'd0 : ifid;
            if (ifid_we) ifid = (pc < n_instr) ? prog_mem[pc] : 17'd0;
            if (pc_we) pc++;
        end
        chk(tag, 32'(bub), 32'(exp_bub));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state with quiet inputs
        id_rs = 5'd5; #1;
        chk("R11 reset read", rd_data_a, 32'd0);
        chk("R6 idle pc_we", 32'(pc_we), 32'd1);
        chk("R6 idle ctrl pass", 32'(id_ctrl_out), 32'h5A);
        id_rs = '0;

        // Forwarding vector table (writeback writes land in the file too)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {ex_rs, ex_rt, mem_wr_en, mem_rd, wb_wr_en, wb_rd} = VECS[i][25:4];
            wb_data = 32'hA000 + 32'(i);
            #1;
            chk($sformatf("R1/R2/R3/R4/R5 vec%0d fwd_a", i), 32'(fwd_a), 32'(VECS[i][3:2]));
            chk($sformatf("R1/R2/R3/R4/R5 vec%0d fwd_b", i), 32'(fwd_b), 32'(VECS[i][1:0]));
        end
        @(negedge clk);
        idle_inputs();

        // R8 a value written in the table is retained (reg 9 written by vector 4)
        id_rs = 5'd9; id_rt = 5'd18; #1;
        chk("R8 stored reg9", rd_data_a, 32'hA004);
        chk("R8 stored reg18", rd_data_b, 32'hA009);

        // R11 reset clears the file
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; #1;
        chk("R11 cleared reg9", rd_data_a, 32'd0);
        chk("R11 cleared reg18", rd_data_b, 32'd0);

        // R6 load-use on first source
        @(negedge clk);
        idle_inputs();
        ex_mem_read = 1'b1; ex_rd = 5'd7; id_rs = 5'd7; id_rt = 5'd2; #1;
        chk("R6 stall rs bubble", 32'(bubble), 32'd1);
        chk("R6 stall pc_we", 32'(pc_we), 32'd0);
        chk("R6 stall ifid_we", 32'(ifid_we), 32'd0);
        chk("R6 stall ctrl zero", 32'(id_ctrl_out), 32'd0);
        // second source
        id_rs = 5'd3; id_rt = 5'd7; #1;
        chk("R6 stall rt bubble", 32'(bubble), 32'd1);
        // load to register 0 never stalls
        ex_rd = 5'd0; id_rs = 5'd0; #1;
        chk("R6 load r0 no stall", 32'(bubble), 32'd0);
        // non-load with match does not stall
        ex_mem_read = 1'b0; ex_rd = 5'd7; id_rs = 5'd7; #1;
        chk("R6 alu no stall", 32'(bubble), 32'd0);
        chk("R6 alu ctrl pass", 32'(id_ctrl_out), 32'h5A);
        chk("R6 alu ifid_we", 32'(ifid_we), 32'd1);

        // R9 same-cycle bypass, then R8 retention
        @(negedge clk);
        idle_inputs();
        wb_wr_en = 1'b1; wb_rd = 5'd20; wb_data = 32'hCAFE_0001; id_rs = 5'd20; #1;
        chk("R9 bypass", rd_data_a, 32'hCAFE_0001);
        @(negedge clk);
        wb_wr_en = 1'b0; wb_data = 32'h0; #1;
        chk("R8 write kept", rd_data_a, 32'hCAFE_0001);

        // R10 register 0 not bypassed and not written
        @(negedge clk);
        wb_wr_en = 1'b1; wb_rd = 5'd0; wb_data = 32'hDEAD_BEEF; id_rs = 5'd0; id_rt = 5'd0; #1;
        chk("R10 r0 no bypass", rd_data_a, 32'd0);
        @(negedge clk);
        wb_wr_en = 1'b0; #1;
        chk("R10 r0 no write", rd_data_b, 32'd0);
        idle_inputs();

        // R7 back-to-back ALU chain: r1 <- ; r2 <- r1 ; r3 <- r2,r1
        prog_mem[0] = {1'b0, 1'b1, 5'd1, 5'd4, 5'd5};
        prog_mem[1] = {1'b0, 1'b1, 5'd2, 5'd1, 5'd6};
        prog_mem[2] = {1'b0, 1'b1, 5'd3, 5'd2, 5'd1};
        run_pipe(3, 0, "R7 alu chain bubbles");

        // R7 load then immediate consumer
        prog_mem[0] = {1'b1, 1'b1, 5'd4, 5'd1, 5'd0};
        prog_mem[1] = {1'b0, 1'b1, 5'd5, 5'd4, 5'd2};
        prog_mem[2] = {1'b0, 1'b1, 5'd6, 5'd5, 5'd4};
        run_pipe(3, 1, "R7 load-use bubbles");

        // R7 load, independent, then consumer
        prog_mem[0] = {1'b1, 1'b1, 5'd6, 5'd1, 5'd0};
        prog_mem[1] = {1'b0, 1'b1, 5'd7, 5'd2, 5'd3};
        prog_mem[2] = {1'b0, 1'b1, 5'd8, 5'd6, 5'd6};
        run_pipe(3, 0, "R7 spaced load bubbles");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule